// File: doc/BRIEF.md
# Reset and Interrupt Priority Resolver

This block looks at every pending reset and interrupt request in a cycle and names the single one to be serviced first. The result is a registered valid flag and a 5-bit source code. A vector fetch stage can use that code directly. Six non-maskable sources sit in a fixed ranking, and any of them beats every maskable source. The maskable group follows a default order by slot index. A 4-bit promotion field can lift any one maskable slot to the head of that group.

The block also conditions its requests. The external interrupt line is active low. It is either sampled as a level, so that open-drain devices can share it, or caught on a falling edge by a latch. The latch stays set until the resolver grants that source. A global interrupt mask bit blocks the whole maskable group. A separate mask bit blocks the non-maskable external interrupt. The clock-monitor reset counts only while its enable bit is set. The watchdog reset counts only while the "no watchdog" configuration input is low.

Top module: `prio_resolver`

## Requirements
- R1: The non-maskable request bits `nmi_req[5:0]` map to codes 0 to 5, with bit k giving code k. When several are pending together, the lowest code wins. The ranking is: reset (bit 0), clock-monitor reset (1), watchdog reset (2), non-maskable external interrupt (3), illegal-opcode trap (4), software interrupt (5).
- R2: Any enabled non-maskable request wins over every maskable request in the same cycle.
- R3: `nmi_req[1]` is ignored while the clock-monitor enable bit is clear. That bit is clear after reset and is loaded from `cfg_cm_en` on `cfg_we`.
- R4: `nmi_req[2]` is ignored while `cfg_nowdog` is high.
- R5: Both mask bits are set after reset and are loaded from `mask_i` and `mask_x` on `mask_we`. While the I mask is set, no maskable source is granted. While the X mask is set, `nmi_req[3]` is ignored.
- R6: Maskable slot k is reported as code 6+k. Among maskable slots that are not promoted, the lowest slot index wins.
- R7: With promotion field value p < N_MASK, slot p wins over every other maskable slot. Values p >= N_MASK leave the default order unchanged.
- R8: The promotion field resets to 5. Slot 5 is the external interrupt line, so right after reset the external line is the top maskable source.
- R9: Slot 5 of the maskable group is driven only by the external line `irq_n`. The `mreq[5]` input bit is ignored. In level mode (`cfg_irq_edge`=0, the reset setting), the external line requests for as long as `irq_n` is low.
- R10: In edge mode, a falling edge of `irq_n` sets a latch. The latch requests until slot 5 is granted once and then clears. This holds even if the edge arrived while the line was masked. A line held low does not request again.
- R11: `grant_vld` and `grant_idx` change only on a clock edge and reflect the requests present before that edge. With no winner, `grant_vld`=0 and `grant_idx`=0.
- R12: During reset, `grant_vld` is 0 and `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 6 | Non-maskable requests, bit k ranked k (0 highest) |
| cfg_nowdog | input | 1 | High disables the watchdog reset request |
| mreq | input | N_MASK | Maskable requests by slot; bit 5 unused |
| irq_n | input | 1 | Active-low external interrupt line |
| cfg_we | input | 1 | Loads promotion field, edge mode and clock-monitor enable |
| cfg_psel | input | 4 | New promotion field value |
| cfg_irq_edge | input | 1 | New external line mode: 1 falling edge, 0 level |
| cfg_cm_en | input | 1 | New clock-monitor enable |
| mask_we | input | 1 | Loads both mask bits |
| mask_i | input | 1 | New global maskable-interrupt mask |
| mask_x | input | 1 | New non-maskable external interrupt mask |
| grant_vld | output | 1 | A source is granted |
| grant_idx | output | 5 | Code of the granted source |

## Verification
The bench builds the block with the default N_MASK of 12. This places the external line at slot 5 among twelve slots and leaves promotion values 12 to 15 without a source. As a result, both the promoted case and the unassigned-value fallback are reachable. With twelve slots, the maskable pair sweep also covers collisions on both sides of the external line's slot, plus every pair of non-maskable sources.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int NMI_N    = 6;
    localparam int IDX_W    = 5;
    localparam int PSEL_W   = 4;
    localparam int IRQ_SLOT = 5;
    localparam logic [PSEL_W-1:0] PSEL_RST = 4'd5;

    typedef enum logic [IDX_W-1:0] {
        SRC_RESET  = 5'd0,
        SRC_CLKMON = 5'd1,
        SRC_WDOG   = 5'd2,
        SRC_XINT   = 5'd3,
        SRC_ILLOP  = 5'd4,
        SRC_SWI    = 5'd5
    } nmi_src_e;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
    } grant_t;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              irq_edge;
        logic              cm_en;
    } cfg_t;

    // Position of the lowest set bit of a 6-bit vector.
    function automatic logic [IDX_W-1:0] lowest6(input logic [NMI_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = NMI_N - 1; k >= 0; k--) begin
            if (v[k]) r = IDX_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_front.sv
module irq_front (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic ack,
    output logic req
);
    logic prev_n_q;
    logic latch_q;
    logic fall;

    assign fall = prev_n_q & ~irq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n_q <= 1'b1;
            latch_q  <= 1'b0;
        end else begin
            prev_n_q <= irq_n;
            if (!edge_mode)   latch_q <= 1'b0;
            else if (fall)    latch_q <= 1'b1;
            else if (ack)     latch_q <= 1'b0;
        end
    end

    assign req = edge_mode ? latch_q : ~irq_n;
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
    import prio_pkg::*;
(
    input  logic [NMI_N-1:0] raw,
    input  logic             cm_en,
    input  logic             nowdog,
    input  logic             x_mask,
    output logic [NMI_N-1:0] gated
);
    always_comb begin
        gated = raw;
        gated[SRC_CLKMON] = raw[SRC_CLKMON] & cm_en;
        gated[SRC_WDOG]   = raw[SRC_WDOG]   & ~nowdog;
        gated[SRC_XINT]   = raw[SRC_XINT]   & ~x_mask;
    end
endmodule

// File: rtl/mask_arb.sv
module mask_arb
    import prio_pkg::*;
#(
    parameter int N_MASK = 12,
    localparam int MIDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1,
    localparam int SEL_N  = 2 ** PSEL_W
) (
    input  logic [N_MASK-1:0] req,
    input  logic [PSEL_W-1:0] psel,
    output logic              vld,
    output logic [MIDX_W-1:0] idx
);
    logic [SEL_N-1:0]  padded;
    logic              promoted;
    logic [MIDX_W-1:0] low_idx;

    always_comb begin
        padded = '0;
        padded[N_MASK-1:0] = req;
    end

    assign promoted = padded[psel];

    always_comb begin
        low_idx = '0;
        for (int k = N_MASK - 1; k >= 0; k--) begin
            if (req[k]) low_idx = MIDX_W'(k);
        end
    end

    assign vld = |req;
    assign idx = promoted ? MIDX_W'(psel) : low_idx;
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_pkg::*;
#(
    parameter int N_MASK = 12,
    localparam int MIDX_W = (N_MASK > 1) ? $clog2(N_MASK) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NMI_N-1:0]     nmi_req,
    input  logic                 cfg_nowdog,
    input  logic [N_MASK-1:0]    mreq,
    input  logic                 irq_n,
    input  logic                 cfg_we,
    input  logic [PSEL_W-1:0]    cfg_psel,
    input  logic                 cfg_irq_edge,
    input  logic                 cfg_cm_en,
    input  logic                 mask_we,
    input  logic                 mask_i,
    input  logic                 mask_x,
    output logic                 grant_vld,
    output logic [IDX_W-1:0]     grant_idx
);
    cfg_t   cfg_q;
    logic   i_mask_q;
    logic   x_mask_q;
    grant_t grant_q;
    grant_t grant_d;

    logic [NMI_N-1:0]  nmi_g;
    logic              irq_req;
    logic              irq_ack;
    logic [N_MASK-1:0] m_eff;
    logic              m_vld;
    logic [MIDX_W-1:0] m_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{psel: PSEL_RST, irq_edge: 1'b0, cm_en: 1'b0};
            i_mask_q <= 1'b1;
            x_mask_q <= 1'b1;
        end else begin
            if (cfg_we)  cfg_q <= '{psel: cfg_psel, irq_edge: cfg_irq_edge, cm_en: cfg_cm_en};
            if (mask_we) begin
                i_mask_q <= mask_i;
                x_mask_q <= mask_x;
            end
        end
    end

    nmi_gate u_nmi (
        .raw    (nmi_req),
        .cm_en  (cfg_q.cm_en),
        .nowdog (cfg_nowdog),
        .x_mask (x_mask_q),
        .gated  (nmi_g)
    );

    irq_front u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_n     (irq_n),
        .edge_mode (cfg_q.irq_edge),
        .ack       (irq_ack),
        .req       (irq_req)
    );

    always_comb begin
        m_eff = mreq;
        m_eff[IRQ_SLOT] = irq_req;
        if (i_mask_q) m_eff = '0;
    end

    mask_arb #(.N_MASK(N_MASK)) u_arb (
        .req  (m_eff),
        .psel (cfg_q.psel),
        .vld  (m_vld),
        .idx  (m_idx)
    );

    always_comb begin
        grant_d = '0;
        if (|nmi_g) begin
            grant_d.vld = 1'b1;
            grant_d.idx = lowest6(nmi_g);
        end else if (m_vld) begin
            grant_d.vld = 1'b1;
            grant_d.idx = IDX_W'(NMI_N) + IDX_W'(m_idx);
        end
    end

    assign irq_ack = ~(|nmi_g) & m_vld & (m_idx == MIDX_W'(IRQ_SLOT));

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant_d;
    end

    assign grant_vld = grant_q.vld;
    assign grant_idx = grant_q.idx;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_pkg::*;
#(
    parameter int N_MASK = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [NMI_N-1:0] nmi_req,
    input logic             i_mask_q,
    input logic             cm_en_q,
    input logic             grant_vld,
    input logic [IDX_W-1:0] grant_idx
);
    a_r11_idle_code: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |-> grant_idx == '0);

    a_r1_reset_first: assert property (@(posedge clk) disable iff (rst)
        nmi_req[0] |=> grant_vld && grant_idx == '0);

    a_r2_swi_over_mask: assert property (@(posedge clk) disable iff (rst)
        nmi_req[5] |=> grant_vld && grant_idx <= IDX_W'(5));

    a_r5_imask_blocks: assert property (@(posedge clk) disable iff (rst)
        (i_mask_q && nmi_req == '0) |=> !grant_vld);

    a_r3_clkmon_off: assert property (@(posedge clk) disable iff (rst)
        (!cm_en_q && nmi_req == 6'b000010) |=> !(grant_vld && grant_idx == IDX_W'(1)));

    a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> grant_idx < IDX_W'(NMI_N + N_MASK));
endmodule

bind prio_resolver prio_resolver_chk #(.N_MASK(N_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nmi_req   (nmi_req),
    .i_mask_q  (i_mask_q),
    .cm_en_q   (cfg_q.cm_en),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
);

// File: tb/prio_resolver_tb_top.sv
module prio_resolver_tb_top;
    localparam int NM = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [5:0]    nmi_req;
    logic          cfg_nowdog;
    logic [NM-1:0] mreq;
    logic          irq_n;
    logic          cfg_we;
    logic [3:0]    cfg_psel;
    logic          cfg_irq_edge;
    logic          cfg_cm_en;
    logic          mask_we;
    logic          mask_i;
    logic          mask_x;
    logic          grant_vld;
    logic [4:0]    grant_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    prio_resolver #(.N_MASK(NM)) dut_i (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .cfg_nowdog(cfg_nowdog),
        .mreq(mreq), .irq_n(irq_n), .cfg_we(cfg_we), .cfg_psel(cfg_psel),
        .cfg_irq_edge(cfg_irq_edge), .cfg_cm_en(cfg_cm_en), .mask_we(mask_we),
        .mask_i(mask_i), .mask_x(mask_x), .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    // {nmi[5:0], mreq[11:0], psel[3:0], exp_vld, exp_idx[4:0]}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {6'b000000, 12'h000, 4'd15, 1'b0, 5'd0},   // R11 nothing pending
        {6'b000000, 12'h001, 4'd15, 1'b1, 5'd6},   // R6 slot 0
        {6'b000000, 12'h00C, 4'd15, 1'b1, 5'd8},   // R6 slots 2,3
        {6'b000000, 12'h800, 4'd15, 1'b1, 5'd17},  // R6 top slot
        {6'b000000, 12'h801, 4'd11, 1'b1, 5'd17},  // R7 promoted 11
        {6'b000000, 12'h801, 4'd12, 1'b1, 5'd6},   // R7 unassigned value
        {6'b000000, 12'h0A0, 4'd5,  1'b1, 5'd13},  // R9 mreq[5] ignored
        {6'b100000, 12'hFFF, 4'd3,  1'b1, 5'd5},   // R2 swi beats all
        {6'b000110, 12'h000, 4'd15, 1'b1, 5'd1},   // R1 clkmon over wdog
        {6'b111111, 12'hFFF, 4'd0,  1'b1, 5'd0},   // R1 all pending
        {6'b000000, 12'h00A, 4'd3,  1'b1, 5'd9},   // R7 promoted 3
        {6'b000000, 12'h000, 4'd3,  1'b0, 5'd0}    // R7 promoted but idle
    };

    task automatic chk(input string tag, input logic ev, input logic [4:0] ei);
        n_chk++;
        if (grant_vld !== ev || grant_idx !== ei) begin
            n_err++;
            $display("FAIL %s: got vld=%0b idx=%0d, expected vld=%0b idx=%0d",
                     tag, grant_vld, grant_idx, ev, ei);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] p, input logic e, input logic cm);
        cfg_we = 1'b1; cfg_psel = p; cfg_irq_edge = e; cfg_cm_en = cm;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic mask_write(input logic i, input logic x);
        mask_we = 1'b1; mask_i = i; mask_x = x;
        step();
        mask_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got no completion, expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; nmi_req = '0; cfg_nowdog = 1'b0; mreq = '0; irq_n = 1'b1;
        cfg_we = 1'b0; cfg_psel = '0; cfg_irq_edge = 1'b0; cfg_cm_en = 1'b0;
        mask_we = 1'b0; mask_i = 1'b0; mask_x = 1'b0;
        step(); step();
        nmi_req = 6'b111111; mreq = '1;
        step();
        chk("R12 reset state", 1'b0, 5'd0);
        rst = 1'b0; nmi_req = '0; mreq = '0;
        step();

        // R5: masks set after reset
        mreq = 12'h001; step(); chk("R5 I mask set at reset", 1'b0, 5'd0);
        mreq = '0; nmi_req = 6'b001000; step(); chk("R5 X mask set at reset", 1'b0, 5'd0);
        nmi_req = 6'b010000; step(); chk("R1 illegal trap alone", 1'b1, 5'd4);
        nmi_req = '0;

        // R8 / R9: reset promotion and level mode
        mask_write(1'b0, 1'b0);
        irq_n = 1'b0; mreq = 12'h001; step(); chk("R8 external line promoted at reset", 1'b1, 5'd11);
        step(); chk("R9 level request persists", 1'b1, 5'd11);
        irq_n = 1'b1; mreq = 12'h021; step(); chk("R9 mreq[5] ignored", 1'b1, 5'd6);
        mreq = 12'h020; step(); chk("R9 mreq[5] alone ignored", 1'b0, 5'd0);
        mreq = '0;

        // R3: clock monitor disabled at reset
        nmi_req = 6'b000010; step(); chk("R3 clkmon off at reset", 1'b0, 5'd0);
        nmi_req = '0;
        cfg_write(4'd15, 1'b0, 1'b1);
        nmi_req = 6'b000010; step(); chk("R3 clkmon enabled", 1'b1, 5'd1);

        // R4: watchdog gate
        cfg_nowdog = 1'b1; nmi_req = 6'b000100; step(); chk("R4 watchdog off", 1'b0, 5'd0);
        nmi_req = 6'b100100; step(); chk("R4 swi with watchdog off", 1'b1, 5'd5);
        cfg_nowdog = 1'b0; nmi_req = 6'b000100; step(); chk("R4 watchdog on", 1'b1, 5'd2);
        nmi_req = '0;

        // R5: X mask alone
        mask_write(1'b0, 1'b1);
        nmi_req = 6'b001000; step(); chk("R5 X mask blocks", 1'b0, 5'd0);
        nmi_req = '0; mreq = 12'h001; step(); chk("R5 I clear with X set", 1'b1, 5'd6);
        mreq = '0;
        mask_write(1'b0, 1'b0);
        nmi_req = 6'b001000; step(); chk("R5 X mask clear", 1'b1, 5'd3);
        nmi_req = '0;

        // R11: registered output
        step(); chk("R11 idle", 1'b0, 5'd0);
        nmi_req = 6'b000001; #1;
        chk("R11 no change before edge", 1'b0, 5'd0);
        step(); chk("R11 after edge", 1'b1, 5'd0);
        nmi_req = '0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            cfg_write(VEC[v][9:6], 1'b0, 1'b1);
            nmi_req = VEC[v][27:22]; mreq = VEC[v][21:10];
            step();
            chk($sformatf("R6/R7/R1/R2 vector %0d", v), VEC[v][5], VEC[v][4:0]);
            nmi_req = '0; mreq = '0;
        end

        // R1: every non-maskable pair
        for (int i = 0; i < 6; i++) begin
            for (int j = i + 1; j < 6; j++) begin
                nmi_req = 6'((1 << i) | (1 << j)); step();
                chk($sformatf("R1 pair %0d,%0d", i, j), 1'b1, 5'(i));
            end
        end
        // R2: each non-maskable over all maskable
        for (int i = 0; i < 6; i++) begin
            nmi_req = 6'(1 << i); mreq = '1; step();
            chk($sformatf("R2 nmi %0d over maskable", i), 1'b1, 5'(i));
        end
        nmi_req = '0; mreq = '0;

        // R6 / R7: every maskable pair, default and promoted
        for (int a = 0; a < NM; a++) begin
            for (int b = a + 1; b < NM; b++) begin
                if (a != 5 && b != 5) begin
                    cfg_write(4'd15, 1'b0, 1'b1);
                    mreq = NM'((1 << a) | (1 << b)); step();
                    chk($sformatf("R6 pair %0d,%0d", a, b), 1'b1, 5'(6 + a));
                    mreq = '0;
                    cfg_write(4'(b), 1'b0, 1'b1);
                    mreq = NM'((1 << a) | (1 << b)); step();
                    chk($sformatf("R7 promote %0d over %0d", b, a), 1'b1, 5'(6 + b));
                    mreq = '0;
                end
            end
        end

        // R10: edge mode
        cfg_write(4'd5, 1'b1, 1'b1);
        irq_n = 1'b1; step();
        irq_n = 1'b0; step(); chk("R10 edge seen, latch not yet", 1'b0, 5'd0);
        step(); chk("R10 latched edge granted", 1'b1, 5'd11);
        step(); chk("R10 cleared after grant", 1'b0, 5'd0);
        step(); chk("R10 held low no rerequest", 1'b0, 5'd0);
        irq_n = 1'b1; step(); chk("R10 rising edge ignored", 1'b0, 5'd0);
        mask_write(1'b1, 1'b0);
        irq_n = 1'b0; step(); step(); chk("R10 latched while masked", 1'b0, 5'd0);
        step(); chk("R10 still masked", 1'b0, 5'd0);
        mask_write(1'b0, 1'b0);
        step(); chk("R10 held edge granted after unmask", 1'b1, 5'd11);
        step(); chk("R10 cleared after late grant", 1'b0, 5'd0);
        irq_n = 1'b1;
        step();

        finish_run();
    end
endmodule